// File: doc/BRIEF.md
# Load Ordering Violation Detector

This block watches loads that ran speculatively before older stores had produced their addresses. Each load in flight holds a slot in a small queue. The slot keeps the load's program-order tag, whether it has executed, a slice of its address and a replay counter. When a store produces its address, every executed load that is younger than the store is compared against it. If any of them touched the same address slice, the block raises a flush request one cycle later. The request names the oldest such load, so that the pipeline can drop dependent work and restart from that load.

Only a slice of the address is compared, and this is intended. Two accesses that differ only outside the slice are still treated as a conflict. This costs a spurious restart but keeps the comparator narrow. A restart bumps the load's replay counter. Once the counter reaches three, the load is held back until every older store has resolved, and it no longer takes part in comparisons. A single load is therefore restarted at most three times.

The issue logic picks the queue slot on allocation and reuses the same slot when a restarted load executes again. Retire frees a slot.

Top module: `ldq_order_guard`

## Requirements
- R1: During and right after reset, no flush is requested, every slot is empty and wait_mask is all zeros.
- R2: A store resolve in cycle N that conflicts with a queued load drives flush_vld high for exactly one cycle, visible after the clock edge that ends cycle N. flush_tag and flush_idx carry that load's tag and slot.
- R3: A load takes part only if its slot is valid, it executed in an earlier cycle, and its tag is strictly younger than the store tag. Older loads and loads that have not executed never cause a flush.
- R4: When several loads match, the oldest one by tag is reported.
- R5: Addresses are compared on bits [CMP_LO+CMP_W-1:CMP_LO] only, which is [11:3] by default. A difference confined to other bits still flushes. A difference inside the slice does not.
- R6: A tag's MSB is a wrap bit. If the wrap bits are equal, the smaller lower field is older. If they differ, the larger lower field is older.
- R7: A flush invalidates every entry younger than the reported load, including one allocated in the same cycle. The reported entry stays valid, has its executed flag cleared and its replay count increased by one. Killed entries can never be reported later.
- R8: After its third restart, a load's wait_mask bit is 1 until it executes. After that it never causes a flush.
- R9: A retired slot is empty and causes no further flush.
- R10: Allocation clears a slot's executed flag and replay count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld | input | 1 | Allocate a load into a slot |
| alloc_idx | input | IDX_W | Slot being allocated |
| alloc_tag | input | ORD_W | Program-order tag of the load, MSB is the wrap bit |
| exec_vld | input | 1 | A queued load executes |
| exec_idx | input | IDX_W | Slot of the executing load |
| exec_addr | input | ADDR_W | Address the load read |
| st_vld | input | 1 | A store resolves its address |
| st_tag | input | ORD_W | Program-order tag of the store |
| st_addr | input | ADDR_W | Resolved store address |
| retire_vld | input | 1 | Free a slot |
| retire_idx | input | IDX_W | Slot being freed |
| flush_vld | output | 1 | One-cycle flush request |
| flush_tag | output | ORD_W | Tag of the load to restart from |
| flush_idx | output | IDX_W | Slot of that load |
| wait_mask | output | DEPTH | Slots whose load must wait for all older stores |

## Verification
The hardest state to reach is a load sitting on its saturated replay count. Getting there takes three complete violate-and-restart rounds on one slot, each of which re-executes the load and then resolves the same older store again. The bench drives that loop on one slot and checks wait_mask after every round. It then executes the load once more and resolves the store again, to show that no fourth flush occurs. A second hard case is a store resolving in the same cycle as the allocation of a younger load. Both are driven in one cycle, and the later silence shows that the new entry was killed.

// File: rtl/ldq_order_pkg.sv
package ldq_order_pkg;
   typedef logic [1:0] replay_t;
   localparam replay_t REPLAY_CAP = 2'd3;
endpackage

// File: rtl/ldq_age_cmp.sv
module ldq_age_cmp #(
   parameter int ORD_W = 6
) (
   input  logic [ORD_W-1:0] a_tag,
   input  logic [ORD_W-1:0] b_tag,
   output logic             a_older
);
   localparam int LOW_W = ORD_W - 1;
   logic [LOW_W-1:0] a_low, b_low;
   assign a_low = a_tag[LOW_W-1:0];
   assign b_low = b_tag[LOW_W-1:0];

   always_comb begin
      if (a_tag[ORD_W-1] == b_tag[ORD_W-1]) a_older = (a_low < b_low);
      else                                  a_older = (a_low > b_low);
   end
endmodule

// File: rtl/ldq_entry.sv
module ldq_entry
   import ldq_order_pkg::*;
#(
   parameter int ORD_W = 6,
   parameter int CMP_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_en,
   input  logic [ORD_W-1:0] alloc_tag,
   input  logic             exec_en,
   input  logic [CMP_W-1:0] exec_cmp,
   input  logic             retire_en,
   input  logic             st_en,
   input  logic [ORD_W-1:0] st_tag,
   input  logic [CMP_W-1:0] st_cmp,
   input  logic             fl_en,
   input  logic [ORD_W-1:0] fl_tag,
   input  logic             fl_self,
   output logic             vld_o,
   output logic             exec_o,
   output logic [ORD_W-1:0] tag_o,
   output logic             match_o,
   output logic             wait_o
);
   logic             vld_q, exec_q;
   logic [ORD_W-1:0] tag_q, tag_d;
   logic [CMP_W-1:0] cmp_q;
   replay_t          cnt_q;
   logic             st_is_older, fl_is_older, saturated;

   assign tag_d     = alloc_en ? alloc_tag : tag_q;
   assign saturated = (cnt_q == REPLAY_CAP);

   ldq_age_cmp #(.ORD_W(ORD_W)) u_st_age (
      .a_tag(st_tag), .b_tag(tag_q), .a_older(st_is_older));
   ldq_age_cmp #(.ORD_W(ORD_W)) u_fl_age (
      .a_tag(fl_tag), .b_tag(tag_d), .a_older(fl_is_older));

   assign match_o = st_en & vld_q & exec_q & ~saturated & st_is_older
                  & (cmp_q == st_cmp);
   assign wait_o  = vld_q & saturated & ~exec_q;
   assign vld_o   = vld_q;
   assign exec_o  = exec_q;
   assign tag_o   = tag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         exec_q <= 1'b0;
         tag_q  <= '0;
         cmp_q  <= '0;
         cnt_q  <= '0;
      end else begin
         if (alloc_en) begin
            vld_q  <= 1'b1;
            tag_q  <= alloc_tag;
            exec_q <= 1'b0;
            cnt_q  <= '0;
         end
         if (exec_en) begin
            exec_q <= 1'b1;
            cmp_q  <= exec_cmp;
         end
         if (retire_en) vld_q <= 1'b0;
         if (fl_en) begin
            if (fl_self) begin
               exec_q <= 1'b0;
               cnt_q  <= cnt_q + replay_t'(1);
            end else if (fl_is_older) begin
               vld_q <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/ldq_oldest_pick.sv
module ldq_oldest_pick #(
   parameter int DEPTH = 8,
   parameter int ORD_W = 6,
   parameter int IDX_W = 3
) (
   input  logic [DEPTH-1:0]            match,
   input  logic [DEPTH-1:0][ORD_W-1:0] tags,
   output logic                        any,
   output logic [DEPTH-1:0]            win,
   output logic [IDX_W-1:0]            win_idx,
   output logic [ORD_W-1:0]            win_tag
);
   logic [DEPTH-1:0][DEPTH-1:0] older;

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      for (genvar j = 0; j < DEPTH; j++) begin : g_col
         if (i == j) begin : g_diag
            assign older[i][j] = 1'b0;
         end else begin : g_cmp
            ldq_age_cmp #(.ORD_W(ORD_W)) u_age (
               .a_tag(tags[i]), .b_tag(tags[j]), .a_older(older[i][j]));
         end
      end
   end

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         win[i] = match[i];
         for (int j = 0; j < DEPTH; j++) begin
            if (j != i && match[j] && !older[i][j]) win[i] = 1'b0;
         end
      end
   end

   always_comb begin
      win_idx = '0;
      win_tag = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (win[i]) begin
            win_idx = win_idx | IDX_W'(i);
            win_tag = win_tag | tags[i];
         end
      end
   end

   assign any = |match;
endmodule

// File: rtl/ldq_order_guard.sv
module ldq_order_guard
   import ldq_order_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int ORD_W  = 6,
   parameter int ADDR_W = 32,
   parameter int CMP_LO = 3,
   parameter int CMP_W  = 9,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_vld,
   input  logic [IDX_W-1:0]  alloc_idx,
   input  logic [ORD_W-1:0]  alloc_tag,
   input  logic              exec_vld,
   input  logic [IDX_W-1:0]  exec_idx,
   input  logic [ADDR_W-1:0] exec_addr,
   input  logic              st_vld,
   input  logic [ORD_W-1:0]  st_tag,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic              retire_vld,
   input  logic [IDX_W-1:0]  retire_idx,
   output logic              flush_vld,
   output logic [ORD_W-1:0]  flush_tag,
   output logic [IDX_W-1:0]  flush_idx,
   output logic [DEPTH-1:0]  wait_mask
);
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if ((1 << (ORD_W - 1)) < DEPTH) begin : g_bad_tag
      $error("tag space must cover the queue depth");
   end
   if (CMP_W < 1 || CMP_LO < 0 || CMP_LO + CMP_W > ADDR_W) begin : g_bad_cmp
      $error("compare slice lies outside the address");
   end

   logic [CMP_W-1:0] exec_cmp, st_cmp;
   if (CMP_W == ADDR_W) begin : g_full_cmp
      assign exec_cmp = exec_addr;
      assign st_cmp   = st_addr;
   end else begin : g_slice_cmp
      assign exec_cmp = exec_addr[CMP_LO +: CMP_W];
      assign st_cmp   = st_addr[CMP_LO +: CMP_W];
      logic addr_unused;
      assign addr_unused = ^{exec_addr, st_addr};
   end

   logic [DEPTH-1:0]            q_valid, q_exec, q_match, q_wait, win;
   logic [DEPTH-1:0][ORD_W-1:0] q_tag;
   logic                        hit;
   logic [IDX_W-1:0]            hit_idx;
   logic [ORD_W-1:0]            hit_tag;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      ldq_entry #(.ORD_W(ORD_W), .CMP_W(CMP_W)) u_entry (
         .clk      (clk),
         .rst_n    (rst_n),
         .alloc_en (alloc_vld  && alloc_idx  == IDX_W'(i)),
         .alloc_tag(alloc_tag),
         .exec_en  (exec_vld   && exec_idx   == IDX_W'(i)),
         .exec_cmp (exec_cmp),
         .retire_en(retire_vld && retire_idx == IDX_W'(i)),
         .st_en    (st_vld),
         .st_tag   (st_tag),
         .st_cmp   (st_cmp),
         .fl_en    (hit),
         .fl_tag   (hit_tag),
         .fl_self  (win[i]),
         .vld_o    (q_valid[i]),
         .exec_o   (q_exec[i]),
         .tag_o    (q_tag[i]),
         .match_o  (q_match[i]),
         .wait_o   (q_wait[i])
      );
   end

   ldq_oldest_pick #(.DEPTH(DEPTH), .ORD_W(ORD_W), .IDX_W(IDX_W)) u_pick (
      .match  (q_match),
      .tags   (q_tag),
      .any    (hit),
      .win    (win),
      .win_idx(hit_idx),
      .win_tag(hit_tag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_vld <= 1'b0;
         flush_tag <= '0;
         flush_idx <= '0;
      end else begin
         flush_vld <= hit;
         if (hit) begin
            flush_tag <= hit_tag;
            flush_idx <= hit_idx;
         end
      end
   end

   assign wait_mask = q_wait;
endmodule

// File: rtl/ldq_order_guard_chk.sv
module ldq_order_guard_chk #(
   parameter int DEPTH = 8,
   parameter int ORD_W = 6,
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             st_vld,
   input logic [ORD_W-1:0] st_tag,
   input logic             retire_vld,
   input logic [IDX_W-1:0] retire_idx,
   input logic             flush_vld,
   input logic [ORD_W-1:0] flush_tag,
   input logic [IDX_W-1:0] flush_idx,
   input logic [DEPTH-1:0] wait_mask,
   input logic [DEPTH-1:0] q_valid,
   input logic [DEPTH-1:0] q_exec
);
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!flush_vld && wait_mask == '0 && q_valid == '0));

   assert_flush_from_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      flush_vld |-> $past(st_vld));

   assert_flush_younger_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flush_vld |->
         (($past(st_tag[ORD_W-1]) == flush_tag[ORD_W-1])
            ? ($past(st_tag[ORD_W-2:0]) < flush_tag[ORD_W-2:0])
            : ($past(st_tag[ORD_W-2:0]) > flush_tag[ORD_W-2:0])));

   assert_restart_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush_vld |-> (q_valid[flush_idx] && !q_exec[flush_idx]));

   assert_retire_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
      retire_vld |=> !q_valid[$past(retire_idx)]);
endmodule

bind ldq_order_guard ldq_order_guard_chk #(.DEPTH(DEPTH), .ORD_W(ORD_W), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st_vld    (st_vld),
   .st_tag    (st_tag),
   .retire_vld(retire_vld),
   .retire_idx(retire_idx),
   .flush_vld (flush_vld),
   .flush_tag (flush_tag),
   .flush_idx (flush_idx),
   .wait_mask (wait_mask),
   .q_valid   (q_valid),
   .q_exec    (q_exec)
);

// File: tb/sim_ldq_order_guard.sv
`timescale 1ns/1ps
module sim_ldq_order_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alloc_vld = 1'b0, exec_vld = 1'b0, st_vld = 1'b0, retire_vld = 1'b0;
   logic [2:0]  alloc_idx = '0, exec_idx = '0, retire_idx = '0;
   logic [5:0]  alloc_tag = '0, st_tag = '0;
   logic [31:0] exec_addr = '0, st_addr = '0;
   logic        flush_vld;
   logic [5:0]  flush_tag;
   logic [2:0]  flush_idx;
   logic [7:0]  wait_mask;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ldq_order_guard u0 (
      .clk(clk), .rst_n(rst_n),
      .alloc_vld(alloc_vld), .alloc_idx(alloc_idx), .alloc_tag(alloc_tag),
      .exec_vld(exec_vld), .exec_idx(exec_idx), .exec_addr(exec_addr),
      .st_vld(st_vld), .st_tag(st_tag), .st_addr(st_addr),
      .retire_vld(retire_vld), .retire_idx(retire_idx),
      .flush_vld(flush_vld), .flush_tag(flush_tag), .flush_idx(flush_idx),
      .wait_mask(wait_mask));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_alloc(input logic [2:0] idx, input logic [5:0] tag);
      @(negedge clk); alloc_vld = 1'b1; alloc_idx = idx; alloc_tag = tag;
      @(negedge clk); alloc_vld = 1'b0;
   endtask

   task automatic do_exec(input logic [2:0] idx, input logic [31:0] addr);
      @(negedge clk); exec_vld = 1'b1; exec_idx = idx; exec_addr = addr;
      @(negedge clk); exec_vld = 1'b0;
   endtask

   task automatic do_retire(input logic [2:0] idx);
      @(negedge clk); retire_vld = 1'b1; retire_idx = idx;
      @(negedge clk); retire_vld = 1'b0;
   endtask

   task automatic do_store(input logic [5:0] tag, input logic [31:0] addr,
                           output bit seen, output logic [5:0] ftag, output logic [2:0] fidx);
      @(negedge clk); st_vld = 1'b1; st_tag = tag; st_addr = addr;
      @(negedge clk); st_vld = 1'b0;
      seen = flush_vld; ftag = flush_tag; fidx = flush_idx;
   endtask

   task automatic t_reset;
      chk(flush_vld == 1'b0, "R1", "flush after reset", 32'(flush_vld), 0);
      chk(wait_mask == 8'h00, "R1", "wait_mask after reset", 32'(wait_mask), 0);
   endtask

   task automatic t_basic;
      bit s; logic [5:0] t; logic [2:0] x;
      do_alloc(3'd0, 6'd5);
      do_exec(3'd0, 32'h0000_1000);
      do_store(6'd3, 32'h0000_1000, s, t, x);
      chk(s, "R2", "flush raised", 32'(s), 1);
      chk(t == 6'd5, "R2", "flush tag", 32'(t), 5);
      chk(x == 3'd0, "R2", "flush slot", 32'(x), 0);
      @(negedge clk);
      chk(flush_vld == 1'b0, "R2", "flush is one cycle", 32'(flush_vld), 0);
      do_retire(3'd0);
   endtask

   task automatic t_filter;
      bit s; logic [5:0] t; logic [2:0] x;
      do_alloc(3'd1, 6'd2);
      do_exec(3'd1, 32'h0000_4440);
      do_alloc(3'd2, 6'd9);
      do_store(6'd5, 32'h0000_4440, s, t, x);
      chk(!s, "R3", "older or unexecuted load flagged", 32'(s), 0);
      do_retire(3'd1);
      do_retire(3'd2);
   endtask

   task automatic t_oldest;
      bit s; logic [5:0] t; logic [2:0] x;
      do_alloc(3'd3, 6'd12); do_exec(3'd3, 32'h0000_2040);
      do_alloc(3'd4, 6'd10); do_exec(3'd4, 32'h0000_2040);
      do_alloc(3'd5, 6'd14); do_exec(3'd5, 32'h0000_2040);
      do_store(6'd8, 32'h0000_2040, s, t, x);
      chk(s && t == 6'd10, "R4", "oldest match tag", 32'(t), 10);
      chk(x == 3'd4, "R4", "oldest match slot", 32'(x), 4);
      do_store(6'd8, 32'h0000_2040, s, t, x);
      chk(!s, "R7", "younger entries killed, restart not executed", 32'(s), 0);
      do_exec(3'd4, 32'h0000_2040);
      do_store(6'd8, 32'h0000_2040, s, t, x);
      chk(s && x == 3'd4, "R7", "restarted load still queued", 32'(x), 4);
      do_retire(3'd4);
   endtask

   task automatic t_partial;
      bit s; logic [5:0] t; logic [2:0] x;
      do_alloc(3'd0, 6'd20);
      do_exec(3'd0, 32'h0000_1238);
      do_store(6'd18, 32'h0000_1A38, s, t, x);
      chk(!s, "R5", "slice bit 11 differs", 32'(s), 0);
      do_store(6'd18, 32'h8000_1238, s, t, x);
      chk(s, "R5", "false flush on high bit difference", 32'(s), 1);
      do_exec(3'd0, 32'h0000_1238);
      do_store(6'd18, 32'h0000_123D, s, t, x);
      chk(s, "R5", "false flush on low bit difference", 32'(s), 1);
      do_retire(3'd0);
   endtask

   task automatic t_wrap;
      bit s; logic [5:0] t; logic [2:0] x;
      do_alloc(3'd6, 6'h22); do_exec(3'd6, 32'h0000_0700);
      do_store(6'h1E, 32'h0000_0700, s, t, x);
      chk(s && t == 6'h22, "R6", "load after wrap is younger", 32'(t), 32'h22);
      do_retire(3'd6);
      do_alloc(3'd7, 6'h1E); do_exec(3'd7, 32'h0000_0700);
      do_store(6'h22, 32'h0000_0700, s, t, x);
      chk(!s, "R6", "load before wrap is older", 32'(s), 0);
      do_retire(3'd7);
   endtask

   task automatic t_replay_cap;
      bit s; logic [5:0] t; logic [2:0] x;
      do_alloc(3'd2, 6'd4);
      for (int k = 1; k <= 3; k++) begin
         do_exec(3'd2, 32'h0000_0900);
         do_store(6'd1, 32'h0000_0900, s, t, x);
         chk(s && x == 3'd2, "R8", "replay round flush", 32'(k), 32'(k));
         chk(wait_mask == ((k == 3) ? 8'h04 : 8'h00), "R8", "wait_mask after round",
             32'(wait_mask), (k == 3) ? 32'h04 : 32'h00);
      end
      do_exec(3'd2, 32'h0000_0900);
      chk(wait_mask == 8'h00, "R8", "wait cleared on execute", 32'(wait_mask), 0);
      do_store(6'd1, 32'h0000_0900, s, t, x);
      chk(!s, "R8", "no fourth flush", 32'(s), 0);
      do_retire(3'd2);
      chk(wait_mask == 8'h00, "R9", "wait_mask after retire", 32'(wait_mask), 0);
      do_alloc(3'd2, 6'd6);
      do_exec(3'd2, 32'h0000_0900);
      do_store(6'd1, 32'h0000_0900, s, t, x);
      chk(s && x == 3'd2, "R10", "reallocated slot compares again", 32'(s), 1);
      chk(wait_mask == 8'h00, "R10", "replay count reset", 32'(wait_mask), 0);
      do_retire(3'd2);
   endtask

   task automatic t_retire;
      bit s; logic [5:0] t; logic [2:0] x;
      do_alloc(3'd1, 6'd7);
      do_exec(3'd1, 32'h0000_0B00);
      do_retire(3'd1);
      do_store(6'd3, 32'h0000_0B00, s, t, x);
      chk(!s, "R9", "retired slot flagged", 32'(s), 0);
   endtask

   task automatic t_same_cycle_kill;
      bit s; logic [5:0] t; logic [2:0] x;
      do_alloc(3'd0, 6'd10);
      do_exec(3'd0, 32'h0000_0C00);
      @(negedge clk);
      st_vld = 1'b1; st_tag = 6'd8; st_addr = 32'h0000_0C00;
      alloc_vld = 1'b1; alloc_idx = 3'd1; alloc_tag = 6'd12;
      @(negedge clk);
      st_vld = 1'b0; alloc_vld = 1'b0;
      chk(flush_vld && flush_idx == 3'd0, "R7", "flush with same-cycle alloc", 32'(flush_idx), 0);
      do_exec(3'd1, 32'h0000_0C00);
      do_store(6'd8, 32'h0000_0C00, s, t, x);
      chk(!s, "R7", "same-cycle younger alloc killed", 32'(s), 0);
      do_retire(3'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_filter();
      t_oldest();
      t_partial();
      t_wrap();
      t_replay_cap();
      t_retire();
      t_same_cycle_kill();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule